// File: doc/BRIEF.md
# Eight-Line GPIO Controller with Per-Pin Interrupt Detection

This block drives and samples eight general purpose pins from a byte-wide register bus with a single-cycle write strobe and a combinational read path. Software sets each pin's direction, writes output values, and reads pin levels. The data port sits in a 1 KB address window. The eight word-address bits that sit above the byte offset act as a per-pin access mask. A read or write touches only the pins whose mask bit is set.

Every pin has its own interrupt detector. The detector can watch for a high or low level, or for a single edge of either polarity, or for both edges. Edge events are held in a status bit until software clears them. Level status simply follows the pin. Enabled status bits are combined into one interrupt line. Pin inputs pass through a synchronizer before any logic uses them. A fixed four-byte identification value can be read at the top of the 4 KB window.

Top module: `gpio8_ctrl`

## Requirements
- R1: A write to byte address 0x000 + (M << 2) updates the output register only on pins whose bit in the 8-bit mask M is 1. All other pins keep their stored output value.
- R2: A read from byte address 0x000 + (M << 2) returns 0 in every bit where M is 0. Where M is 1, it returns the stored output value for an output pin and the synchronized pin level for an input pin.
- R3: The direction register is at 0x400, where a 1 makes the pin an output. It resets to 0x00. pin_oe mirrors it, and pin_out resets to 0x00.
- R4: A data write does not change the stored output value of a pin whose direction bit is 0. When that pin later becomes an output, it drives the value it held before that write.
- R5: A pin level reaches data reads and interrupt detection through two synchronizing flops. A read made one clock after the change shows the old level, and a read made two clocks after shows the new level.
- R6: If a pin's bit at 0x404 is 1, the pin is in level mode. Its raw status is then 1 exactly while the synchronized level equals its bit at 0x40C, where 1 means high and 0 means low. This status is not latched, and a clear write does not affect it.
- R7: If a pin's bit at 0x404 is 0 and its bit at 0x408 is 0, the pin is in single-edge mode. A rising edge sets the raw status when the pin's 0x40C bit is 1, and a falling edge sets it when that bit is 0. The status then stays at 1.
- R8: If a pin's bit at 0x408 is 1 and the pin is in edge mode, both rising and falling edges set the raw status, whatever its 0x40C bit holds.
- R9: Writing 1 to a bit at 0x41C clears that pin's latched edge status, and writing 0 has no effect. If a new edge arrives in the same clock as the clear, the status stays 1.
- R10: The masked status at 0x418 equals the raw status at 0x414 ANDed with the enable register at 0x410. irq_o is 1 exactly when the masked status is non-zero.
- R11: Byte addresses 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x61, 0x10, 0x04 and 0x00, in that order.
- R12: Reads from unused or unaligned addresses return 0. Writes to them, and writes to the read-only status addresses 0x414 and 0x418, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Stored output value |
| pin_oe | output | 8 | Output enable per pin (direction register) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench times a clear write so that it lands in the same clock as a fresh edge event. A design that lets the clear win would lose that interrupt and read back 0. It writes data while pins are inputs and then turns those pins into outputs. A design that stores such writes drives the wrong value once the pins become outputs. It reads the data port one and two clocks after a pin change, which exposes a synchronizer that is too short or too long. It also uses a both-edge pin whose polarity bit selects the opposite edge, so a design that ignores the both-edge bit misses the rising event. It writes a clear to a level-mode pin, and a design that latches level status would keep reporting it after the level has gone away.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
   // word indices (address bits [9:2]) inside the register window 0x400-0x7FC
   localparam logic [7:0] W_DIR   = 8'h00;
   localparam logic [7:0] W_SENSE = 8'h01;
   localparam logic [7:0] W_BOTH  = 8'h02;
   localparam logic [7:0] W_POL   = 8'h03;
   localparam logic [7:0] W_EN    = 8'h04;
   localparam logic [7:0] W_RAW   = 8'h05;
   localparam logic [7:0] W_MSK   = 8'h06;
   localparam logic [7:0] W_CLR   = 8'h07;
   // address bits [11:4] of the identification bytes
   localparam logic [7:0] ID_PAGE = 8'hFE;

   typedef enum logic [1:0] {
      REGION_DATA = 2'b00,
      REGION_CTRL = 2'b01,
      REGION_NONE = 2'b10,
      REGION_TOP  = 2'b11
   } region_e;
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio8_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio8_pin_irq.sv
module gpio8_pin_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic sense_lvl_i,
   input  logic both_i,
   input  logic pol_i,
   input  logic clr_i,
   output logic raw_o
);
   logic prev_q, latch_q;
   logic rise, fall, evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;
   assign evt  = ~sense_lvl_i & (both_i ? (rise | fall) : (pol_i ? rise : fall));

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latch_q <= 1'b0;
      else if (evt)   latch_q <= 1'b1;
      else if (clr_i) latch_q <= 1'b0;
   end

   assign raw_o = sense_lvl_i ? (lvl_i == pol_i) : latch_q;

   a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr_i) |=> latch_q);
   a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt) |=> !latch_q);
   a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !clr_i) |=> latch_q);
   a_r8_both_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_lvl_i && both_i && lvl_i && !prev_q) |=> latch_q);
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl #(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] ID_VALUE    = 32'h0004_1061
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [NUM_PINS-1:0] bus_wdata,
   output logic [NUM_PINS-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_o
);
   import gpio8_pkg::*;

   localparam int unsigned MASK_LSB = 2;
   localparam int unsigned MASK_MSB = MASK_LSB + NUM_PINS - 1;

   if (NUM_PINS != 8) begin : g_bad_pins
      $error("gpio8_ctrl: the address-mask scheme needs NUM_PINS == 8");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("gpio8_ctrl: ADDR_W must be 12 (4 KB window)");
   end

   logic [NUM_PINS-1:0] dir_q, sense_q, both_q, pol_q, en_q, out_q;
   logic [NUM_PINS-1:0] lvl, raw, msk, clr, pin_val, amask;
   logic                aligned, sel_data, sel_ctrl, sel_id;
   logic [7:0]          word;
   region_e             region;

   assign region   = region_e'(bus_addr[ADDR_W-1:ADDR_W-2]);
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign word     = bus_addr[MASK_MSB:MASK_LSB];
   assign amask    = bus_addr[MASK_MSB:MASK_LSB];
   assign sel_data = aligned && (region == REGION_DATA);
   assign sel_ctrl = aligned && (region == REGION_CTRL);
   assign sel_id   = aligned && (bus_addr[ADDR_W-1:4] == ID_PAGE);

   gpio8_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         sense_q <= '0;
         both_q  <= '0;
         pol_q   <= '0;
         en_q    <= '0;
      end else if (bus_we && sel_ctrl) begin
         case (word)
            W_DIR:   dir_q   <= bus_wdata;
            W_SENSE: sense_q <= bus_wdata;
            W_BOTH:  both_q  <= bus_wdata;
            W_POL:   pol_q   <= bus_wdata;
            W_EN:    en_q    <= bus_wdata;
            default: ;
         endcase
      end
   end

   // output data: per-pin write gated by address mask and direction
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            out_q[i] <= 1'b0;
         else if (bus_we && sel_data && amask[i] && dir_q[i])
            out_q[i] <= bus_wdata[i];
      end

      a_r4_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && sel_data && !dir_q[i]) |=> $stable(out_q[i]));
      a_r1_unmasked_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && sel_data && !amask[i]) |=> $stable(out_q[i]));
   end

   assign clr = (bus_we && sel_ctrl && word == W_CLR) ? bus_wdata : '0;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio8_pin_irq u_irq (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl_i      (lvl[i]),
         .sense_lvl_i(sense_q[i]),
         .both_i     (both_q[i]),
         .pol_i      (pol_q[i]),
         .clr_i      (clr[i]),
         .raw_o      (raw[i])
      );
   end

   assign msk     = raw & en_q;
   assign irq_o   = |msk;
   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign pin_val = (dir_q & out_q) | (~dir_q & lvl);

   always_comb begin
      bus_rdata = '0;
      if (sel_data) begin
         bus_rdata = pin_val & amask;
      end else if (sel_ctrl) begin
         case (word)
            W_DIR:   bus_rdata = dir_q;
            W_SENSE: bus_rdata = sense_q;
            W_BOTH:  bus_rdata = both_q;
            W_POL:   bus_rdata = pol_q;
            W_EN:    bus_rdata = en_q;
            W_RAW:   bus_rdata = raw;
            W_MSK:   bus_rdata = msk;
            default: bus_rdata = '0;
         endcase
      end else if (sel_id) begin
         bus_rdata = ID_VALUE[8*bus_addr[3:2] +: 8];
      end
   end

   a_r3_oe_follows_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_ctrl && word == W_DIR) |=> (pin_oe == $past(bus_wdata)));
   a_r12_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !(sel_ctrl && word <= W_EN)) |=> ($stable(en_q) && $stable(dir_q)));
endmodule

// File: tb/gpio8_ctrl_tb_top.sv
module gpio8_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out, pin_oe;
   logic        irq_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // scoreboard queues: expected value, which output, requirement tag
   logic [7:0] q_exp [$];
   int         q_sel [$];
   string      q_tag [$];
   event       sample_ev;

   always #2 clk = ~clk;   // 250 MHz

   gpio8_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
   );

   // monitor: pops one expectation per sample event and compares
   initial begin
      forever begin
         @(sample_ev);
         while (q_exp.size() != 0) begin
            logic [7:0] e, a;
            int         s;
            string      t;
            e = q_exp.pop_front();
            s = q_sel.pop_front();
            t = q_tag.pop_front();
            case (s)
               0:       a = bus_rdata;
               1:       a = pin_out;
               2:       a = pin_oe;
               default: a = {7'd0, irq_o};
            endcase
            total++;
            if (a !== e) begin
               bad++;
               $display("FAIL %s: actual=%02h expected=%02h", t, a, e);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   // read: address set at a falling edge, sampled 1 ns later
   task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      bus_addr = a;
      #1;
      q_exp.push_back(e); q_sel.push_back(0); q_tag.push_back(t);
      ->sample_ev;
   endtask

   task automatic chk(input int s, input logic [7:0] e, input string t);
      @(negedge clk);
      #1;
      q_exp.push_back(e); q_sel.push_back(s); q_tag.push_back(t);
      ->sample_ev;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   initial begin : watchdog
      for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      // R3 reset state
      rd(12'h400, 8'h00, "R3 dir reset");
      chk(1, 8'h00, "R3 pin_out reset");
      chk(2, 8'h00, "R3 pin_oe reset");
      chk(3, 8'h00, "R10 irq reset");
      wr(12'h400, 8'h0F);
      chk(2, 8'h0F, "R3 pin_oe follows dir");
      rd(12'h400, 8'h0F, "R3 dir readback");
      // R4 write all pins: only outputs take it
      wr(12'h3FC, 8'hFF);
      chk(1, 8'h0F, "R4 input pins not written");
      // R1 mask 0x05 write zeros
      wr(12'h014, 8'h00);
      chk(1, 8'h0A, "R1 masked write");
      wr(12'h400, 8'hFF);
      chk(1, 8'h0A, "R4 old value after becoming output");
      // R2 masked reads
      rd(12'h03C, 8'h0A, "R2 mask 0F");
      rd(12'h008, 8'h02, "R2 mask 02");
      rd(12'h004, 8'h00, "R2 mask 01");
      // R5 synchronizer latency on input pins
      wr(12'h400, 8'h00);
      rd(12'h3FC, 8'h00, "R2 input pins low");
      @(negedge clk) pin_in = 8'hA5;
      rd(12'h3FC, 8'h00, "R5 one clock old level");
      rd(12'h3FC, 8'hA5, "R5 two clocks new level");
      idle(4);
      rd(12'h414, 8'h00, "R7 rising ignored in falling mode");
      // R7 single edge
      wr(12'h410, 8'h01);
      wr(12'h40C, 8'h01);
      wr(12'h41C, 8'hFF);
      @(negedge clk) pin_in[0] = 1'b0;
      idle(4);
      rd(12'h414, 8'h00, "R7 falling ignored in rising mode");
      @(negedge clk) pin_in[0] = 1'b1;
      idle(4);
      rd(12'h414, 8'h01, "R7 rising latched");
      rd(12'h418, 8'h01, "R10 masked status");
      chk(3, 8'h01, "R10 irq high");
      @(negedge clk) pin_in[2] = 1'b0;
      idle(4);
      rd(12'h414, 8'h05, "R7 falling latched");
      rd(12'h418, 8'h01, "R10 disabled pin masked");
      // R9 clear
      wr(12'h41C, 8'h01);
      rd(12'h414, 8'h04, "R9 clear one bit");
      chk(3, 8'h00, "R10 irq low after clear");
      wr(12'h41C, 8'h04);
      rd(12'h414, 8'h00, "R9 clear second bit");
      // R8 both edges, polarity says falling
      wr(12'h408, 8'h08);
      @(negedge clk) pin_in[3] = 1'b1;
      idle(4);
      rd(12'h414, 8'h08, "R8 rising with both edges");
      wr(12'h41C, 8'h08);
      @(negedge clk) pin_in[3] = 1'b0;
      idle(4);
      rd(12'h414, 8'h08, "R8 falling with both edges");
      wr(12'h41C, 8'h08);
      // R6 level mode on pin 4
      wr(12'h404, 8'h10);
      wr(12'h40C, 8'h11);
      rd(12'h414, 8'h00, "R6 high level inactive");
      @(negedge clk) pin_in[4] = 1'b1;
      idle(3);
      rd(12'h414, 8'h10, "R6 high level active");
      wr(12'h41C, 8'h10);
      rd(12'h414, 8'h10, "R6 clear has no effect on level");
      @(negedge clk) pin_in[4] = 1'b0;
      idle(3);
      rd(12'h414, 8'h00, "R6 level not latched");
      wr(12'h40C, 8'h01);
      rd(12'h414, 8'h10, "R6 low level active");
      wr(12'h404, 8'h00);
      rd(12'h414, 8'h00, "R6 back to edge mode");
      // R9 collision: clear lands in the cycle the edge is latched
      @(negedge clk) pin_in[0] = 1'b0;
      idle(4);
      rd(12'h414, 8'h00, "R9 pre collision");
      @(negedge clk) pin_in[0] = 1'b1;
      @(negedge clk);
      wr(12'h41C, 8'h01);
      rd(12'h414, 8'h01, "R9 edge wins over clear");
      chk(3, 8'h01, "R10 irq after collision");
      wr(12'h410, 8'h00);
      chk(3, 8'h00, "R10 irq masked off");
      rd(12'h418, 8'h00, "R10 masked status zero");
      // R11 identification bytes
      rd(12'hFE0, 8'h61, "R11 id byte 0");
      rd(12'hFE4, 8'h10, "R11 id byte 1");
      rd(12'hFE8, 8'h04, "R11 id byte 2");
      rd(12'hFEC, 8'h00, "R11 id byte 3");
      // R12 unused / read-only
      rd(12'h420, 8'h00, "R12 unused read");
      rd(12'h401, 8'h00, "R12 unaligned read");
      wr(12'h420, 8'hFF);
      wr(12'h401, 8'hFF);
      rd(12'h400, 8'h00, "R12 unused write ignored");
      wr(12'h414, 8'h00);
      wr(12'h418, 8'h00);
      rd(12'h414, 8'h01, "R12 raw status read-only");
      rd(12'h410, 8'h00, "R12 enable untouched");
      idle(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule